// File: doc/BRIEF.md
# I2C Register and Scratch-RAM Target

This block is a slave-only I2C front end that runs on a fast system clock and oversamples the SCL and SDA lines. It answers to one fixed 7-bit device address and keeps a single byte pointer that spans two regions. The lower region holds up to 32 registers that live outside the block and are reached through a simple strobe port. The upper region is a 64-byte scratch RAM held inside the block. The bus master sets the pointer with the first byte of a write and then moves data a byte at a time. The pointer advances after every byte.

Reads can start from the current pointer, or follow a pointer write and a repeated start. A read can run on for as long as the master acknowledges each byte. The pointer never crosses from one region into the other. When it steps past the last location of its region, it wraps back to the first location of that same region. The block drives SDA only through a pull-down enable, so the pad stays open drain. It does not stretch the clock.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the SDA pull-down is released, no register strobe is active, and the pointer is 0x00.
- R2: The first byte after a start (or repeated start) is acknowledged only if its upper seven bits equal 1101111; bit 0 selects read (1) or write (0). Any other control byte is not acknowledged, and the target then ignores the bus, writing nothing, until the next start.
- R3: In a write, every data byte after the pointer byte is acknowledged and stored at the pointer: pointer values 0x00–0x1F raise `reg_wr` for one clock with `reg_addr` and `reg_wdata` valid, and values 0x20–0x5F write the internal RAM.
- R4: A pointer byte above 0x5F is not acknowledged and leaves the pointer unchanged.
- R5: The pointer advances by one after each byte written or read; a read without a preceding pointer byte starts at the current pointer.
- R6: A pointer write followed by a repeated start and a read control byte returns data starting at the loaded pointer.
- R7: A read continues while the master acknowledges each byte. After a master NACK, SDA is released and stays released until the stop.
- R8: The pointer wraps from 0x1F to 0x00 and from 0x5F to 0x20, for both reads and writes.
- R9: The SDA pull-down changes only while SCL is low. An ACK is held for the whole high phase of the ninth clock and is released after the following SCL fall.
- R10: Each byte fetched from the register region raises `reg_rd` for exactly one clock, with `reg_addr` valid and `reg_rdata` captured in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level from the pad |
| sda_in | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | SDA pull-down enable (1 drives the line low) |
| reg_wr | output | 1 | One-clock register write strobe |
| reg_rd | output | 1 | One-clock register read strobe |
| reg_addr | output | 5 | Register index (low pointer bits) |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, combinational from reg_addr |

## Verification
Two events share one system clock. In that clock a data byte is committed or a read byte is fetched, and the pointer steps to its next value, which may wrap inside its region. The bench provokes this with writes and reads that cross 0x1F and 0x5F. These include one 66-byte write that laps the whole RAM, plus random bursts whose start addresses land near both boundaries. Each result is judged by reading the data back against a bench model of both regions and of the wrapping pointer. For register reads, the number of `reg_rd` strobes is also counted.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ADDR,
      ST_WR,
      ST_RD
   } tgt_state_e;

   localparam logic [3:0] BITS_PER_BYTE = 4'd8;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_tgt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stg;

   // Lines idle high, so the chain resets to ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
   parameter int REG_DEPTH = 32,
   parameter int RAM_DEPTH = 64,
   localparam int PTR_W = $clog2(REG_DEPTH + RAM_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   input  logic             inc,
   output logic [PTR_W-1:0] ptr
);

   localparam logic [PTR_W-1:0] REG_LAST  = PTR_W'(REG_DEPTH - 1);
   localparam logic [PTR_W-1:0] RAM_FIRST = PTR_W'(REG_DEPTH);
   localparam logic [PTR_W-1:0] RAM_LAST  = PTR_W'(REG_DEPTH + RAM_DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (load) begin
         ptr <= load_val;
      end else if (inc) begin
         if (ptr == REG_LAST)      ptr <= '0;
         else if (ptr == RAM_LAST) ptr <= RAM_FIRST;
         else                      ptr <= ptr + 1'b1;
      end
   end

   p_ptr_in_range_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= RAM_LAST);

   p_wrap_reg_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && ptr == REG_LAST) |=> ptr == '0);

   p_wrap_ram_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && ptr == RAM_LAST) |=> ptr == RAM_FIRST);

   p_load_inc_excl_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !(load && inc));

endmodule

// File: rtl/i2c_tgt_ram.sv
module i2c_tgt_ram #(
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];

   // No reset: contents are undefined until written.
   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
   parameter logic [6:0] DEV_ADDR    = 7'b1101111,
   parameter int         REG_DEPTH   = 32,
   parameter int         RAM_DEPTH   = 64,
   parameter int         SYNC_STAGES = 2,
   localparam int        REG_AW      = $clog2(REG_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic [REG_AW-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   input  logic [7:0]        reg_rdata
);
   import i2c_tgt_pkg::*;

   localparam int PTR_W  = $clog2(REG_DEPTH + RAM_DEPTH);
   localparam int RAM_AW = $clog2(RAM_DEPTH);
   localparam logic [7:0] TOP_ADDR = 8'(REG_DEPTH + RAM_DEPTH - 1);

   generate
      if (PTR_W > 8) begin : g_bad_span
         $error("i2c_reg_target: address span exceeds one address byte");
      end
      if ((1 << REG_AW) != REG_DEPTH) begin : g_bad_reg
         $error("i2c_reg_target: REG_DEPTH must be a power of two");
      end
      if (RAM_DEPTH < 2) begin : g_bad_ram
         $error("i2c_reg_target: RAM_DEPTH must be at least 2");
      end
   endgenerate

   // Line conditioning and edge detection
   logic scl_s, sda_s, scl_q, sda_q;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   logic start_c, stop_c, scl_rise, scl_fall;
   assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;

   // Byte engine state
   tgt_state_e st;
   logic [3:0] cnt;
   logic       in_ack;
   logic [7:0] sh;
   logic       rw;
   logic       mack;
   logic       oe;

   logic [PTR_W-1:0] ptr;
   logic [7:0]       ram_rdata;
   logic [7:0]       rd_byte;
   logic             in_reg, rx_state, ctrl_ok, addr_ok;
   logic             ack_open, ack_close, wr_fire, load_rd, ptr_load, ram_we;

   assign in_reg    = ptr < PTR_W'(REG_DEPTH);
   assign rx_state  = (st == ST_CTRL) || (st == ST_ADDR) || (st == ST_WR);
   assign ctrl_ok   = sh[7:1] == DEV_ADDR;
   assign addr_ok   = sh <= TOP_ADDR;
   assign ack_open  = scl_fall && rx_state && (cnt == BITS_PER_BYTE) && !in_ack;
   assign ack_close = scl_fall && rx_state && in_ack;
   assign wr_fire   = ack_open && (st == ST_WR);
   assign load_rd   = (ack_close && (st == ST_CTRL) && rw) ||
                      (scl_fall && (st == ST_RD) && in_ack && mack);
   assign ptr_load  = ack_open && (st == ST_ADDR) && addr_ok;
   assign ram_we    = wr_fire && !in_reg;
   assign rd_byte   = in_reg ? reg_rdata : ram_rdata;

   assign reg_wr    = wr_fire && in_reg;
   assign reg_rd    = load_rd && in_reg;
   assign reg_addr  = ptr[REG_AW-1:0];
   assign reg_wdata = sh;
   assign sda_oe    = oe;

   i2c_tgt_ptr #(.REG_DEPTH(REG_DEPTH), .RAM_DEPTH(RAM_DEPTH)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(sh[PTR_W-1:0]),
      .inc(wr_fire || load_rd), .ptr(ptr));

   i2c_tgt_ram #(.DEPTH(RAM_DEPTH)) u_ram (
      .clk(clk), .we(ram_we), .addr(RAM_AW'(ptr - PTR_W'(REG_DEPTH))),
      .wdata(sh), .rdata(ram_rdata));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         in_ack <= 1'b0;
         sh     <= '0;
         rw     <= 1'b0;
         mack   <= 1'b0;
         oe     <= 1'b0;
      end else if (start_c) begin
         st     <= ST_CTRL;
         cnt    <= '0;
         in_ack <= 1'b0;
         oe     <= 1'b0;
      end else if (stop_c) begin
         st     <= ST_IDLE;
         in_ack <= 1'b0;
         oe     <= 1'b0;
      end else begin
         case (st)
            ST_CTRL, ST_ADDR, ST_WR: begin
               if (scl_rise && !in_ack && cnt < BITS_PER_BYTE) begin
                  sh  <= {sh[6:0], sda_s};
                  cnt <= cnt + 1'b1;
               end else if (ack_open) begin
                  if ((st == ST_CTRL && !ctrl_ok) || (st == ST_ADDR && !addr_ok)) begin
                     st <= ST_IDLE;
                  end else begin
                     oe     <= 1'b1;
                     in_ack <= 1'b1;
                     if (st == ST_CTRL) rw <= sh[0];
                  end
               end else if (ack_close) begin
                  in_ack <= 1'b0;
                  cnt    <= '0;
                  oe     <= 1'b0;
                  if (st == ST_CTRL && rw) begin
                     st <= ST_RD;
                     sh <= rd_byte;
                     oe <= ~rd_byte[7];
                  end else if (st == ST_CTRL) begin
                     st <= ST_ADDR;
                  end else begin
                     st <= ST_WR;
                  end
               end
            end
            ST_RD: begin
               if (scl_rise && !in_ack) begin
                  cnt <= cnt + 1'b1;
               end else if (scl_rise && in_ack) begin
                  mack <= ~sda_s;
               end else if (scl_fall) begin
                  if (in_ack) begin
                     in_ack <= 1'b0;
                     if (mack) begin
                        sh  <= rd_byte;
                        oe  <= ~rd_byte[7];
                        cnt <= '0;
                     end else begin
                        oe <= 1'b0;
                        st <= ST_IDLE;
                     end
                  end else if (cnt == BITS_PER_BYTE) begin
                     oe     <= 1'b0;
                     in_ack <= 1'b1;
                  end else begin
                     sh <= {sh[6:0], 1'b0};
                     oe <= ~sh[6];
                  end
               end
            end
            default: ;
         endcase
      end
   end

   p_oe_steady_scl_high_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && scl_q) |-> oe == $past(oe));

   p_stop_releases_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      stop_c |=> !oe);

   p_idle_quiet_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !reg_wr && !reg_rd);

   p_strobe_one_clock_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);

endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;

   localparam int H = 12;
   localparam int Q = 5;
   localparam logic [7:0] CTRL_W = 8'hDE;
   localparam logic [7:0] CTRL_R = 8'hDF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe, reg_wr, reg_rd;
   logic [4:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   wire sda_w = sda_m & ~sda_oe;

   always #4 clk = ~clk;

   i2c_reg_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_w),
      .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   // Register file outside the block
   logic [7:0] regs [32];
   assign reg_rdata = regs[reg_addr];
   always @(posedge clk) if (reg_wr) regs[reg_addr] <= reg_wdata;

   int wr_cnt = 0, rd_cnt = 0;
   always @(posedge clk) begin
      if (reg_wr) wr_cnt <= wr_cnt + 1;
      if (reg_rd) rd_cnt <= rd_cnt + 1;
   end

   // SDA driver may move only while SCL is low
   int   viol = 0;
   logic oe_prev = 1'b0, scl_prev = 1'b1;
   always @(negedge clk) begin
      if (scl_m && scl_prev && sda_oe != oe_prev) viol++;
      oe_prev  = sda_oe;
      scl_prev = scl_m;
   end

   int checks = 0, errors = 0;
   bit done = 0;
   logic [7:0] exp_mem [96];
   logic [7:0] wbuf [80];
   int exp_ptr = 0;

   function automatic int nxt(input int p);
      if (p == 31) return 0;
      if (p == 95) return 32;
      return p + 1;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked, output logic held);
      logic a1, a2;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(H);
         scl_m = 1'b1; tick(H);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H / 4);
      a1 = ~sda_w;  tick(H / 2);
      a2 = ~sda_w;  tick(H - H / 4 - H / 2);
      scl_m = 1'b0; tick(Q);
      acked = a1 & a2;
      held  = (a1 == a2);
   endtask

   task automatic read_byte(input bit ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(H);
         scl_m = 1'b1; tick(H / 2);
         b[i] = sda_w; tick(H - H / 2);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = ~ack; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic wr_seq(input logic [7:0] a, input int n);
      logic ak, hd;
      bus_start();
      send_byte(CTRL_W, ak, hd);
      check(ak && hd, "R2 control byte ACK held (R9)", ak, 1);
      send_byte(a, ak, hd);
      check(ak, "R3 pointer byte ACK", ak, 1);
      check(!sda_oe, "R9 ACK released after SCL fall", sda_oe, 0);
      exp_ptr = a;
      for (int k = 0; k < n; k++) begin
         send_byte(wbuf[k], ak, hd);
         check(ak, "R3 data byte ACK", ak, 1);
         exp_mem[exp_ptr] = wbuf[k];
         exp_ptr = nxt(exp_ptr);
      end
      bus_stop();
   endtask

   task automatic rd_seq(input logic [7:0] a, input int n, input bit set_addr, input string tag);
      logic ak, hd;
      logic [7:0] b;
      if (set_addr) begin
         bus_start();
         send_byte(CTRL_W, ak, hd);
         check(ak, "R2 control byte ACK", ak, 1);
         send_byte(a, ak, hd);
         check(ak, "R6 pointer byte ACK", ak, 1);
         exp_ptr = a;
      end
      bus_start();
      send_byte(CTRL_R, ak, hd);
      check(ak && hd, "R2 read control ACK", ak, 1);
      for (int k = 0; k < n; k++) begin
         read_byte(k < n - 1, b);
         check(b == exp_mem[exp_ptr], tag, b, exp_mem[exp_ptr]);
         exp_ptr = nxt(exp_ptr);
      end
      tick(2);
      check(!sda_oe, "R7 SDA released after master NACK", sda_oe, 0);
      tick(H);
      check(!sda_oe, "R7 SDA stays released before stop", sda_oe, 0);
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic ak, hd;
      int base, n, a;
      void'($urandom(32'h1c2d5eed));
      for (int i = 0; i < 32; i++) begin
         regs[i]    = 8'($urandom);
         exp_mem[i] = regs[i];
      end
      tick(10);
      rst_n = 1'b1;
      tick(4);

      // R1 reset state
      check(!sda_oe && !reg_wr && !reg_rd, "R1 idle after reset", sda_oe, 0);

      // R5 current read from reset pointer 0x00
      rd_seq(8'h00, 2, 1'b0, "R5 current read from reset pointer (R1)");

      // R2 foreign address ignored
      base = wr_cnt;
      bus_start();
      send_byte(8'hA0, ak, hd);
      check(!ak, "R2 foreign address NACK", ak, 0);
      send_byte(8'h05, ak, hd);
      check(!ak, "R2 bytes after foreign address ignored", ak, 0);
      bus_stop();
      check(wr_cnt == base, "R2 no write after foreign address", wr_cnt - base, 0);

      // R3 register burst write
      base = wr_cnt;
      for (int k = 0; k < 3; k++) wbuf[k] = 8'($urandom);
      wr_seq(8'h05, 3);
      check(wr_cnt - base == 3, "R3 reg_wr strobes", wr_cnt - base, 3);
      rd_seq(8'h05, 3, 1'b1, "R3 register write read back (R6)");

      // R8 RAM fill with lap of the region
      for (int k = 0; k < 66; k++) wbuf[k] = 8'($urandom);
      wr_seq(8'h20, 66);
      rd_seq(8'h5E, 4, 1'b1, "R8 RAM wrap 0x5F to 0x20");

      // R8 register wrap, write and read, with R10 strobe count
      for (int k = 0; k < 3; k++) wbuf[k] = 8'($urandom);
      wr_seq(8'h1F, 3);
      base = rd_cnt;
      rd_seq(8'h1E, 4, 1'b1, "R8 register wrap 0x1F to 0x00");
      check(rd_cnt - base == 4, "R10 reg_rd per register byte", rd_cnt - base, 4);

      // R5 current read continues after previous read
      rd_seq(8'h00, 2, 1'b0, "R5 current read continues");

      // R4 out-of-range pointer byte
      wr_seq(8'h10, 0);
      bus_start();
      send_byte(CTRL_W, ak, hd);
      check(ak, "R2 control ACK", ak, 1);
      send_byte(8'h60, ak, hd);
      check(!ak, "R4 pointer 0x60 NACK", ak, 0);
      bus_stop();
      bus_start();
      send_byte(CTRL_W, ak, hd);
      send_byte(8'hFF, ak, hd);
      check(!ak, "R4 pointer 0xFF NACK", ak, 0);
      bus_stop();
      rd_seq(8'h00, 1, 1'b0, "R4 pointer unchanged after NACK");

      // Random bursts near and across region ends
      for (int it = 0; it < 16; it++) begin
         case ($urandom_range(0, 2))
            0: a = $urandom_range(27, 31);
            1: a = $urandom_range(91, 95);
            default: a = $urandom_range(0, 95);
         endcase
         n = $urandom_range(1, 6);
         for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
         wr_seq(8'(a), n);
         if ($urandom_range(0, 1) == 1)
            rd_seq(8'(a), n, 1'b1, "R6 random read back");
         else
            rd_seq(8'h00, n, 1'b0, "R5 random current read");
      end

      check(viol == 0, "R9 SDA driver moved while SCL high", viol, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule